// File: doc/BRIEF.md
# Debug Abstract Command Engine

This block is the register-access command engine of a processor debug module. A debugger reaches it over a simple register bus carrying an address, write data, read data and read/write strobes. Through that bus it sees a control/status word (error code, busy flag, data-word count, eight auto-execute bits), a command word, and a set of data words that form a small exchange buffer shared with the hart.

When a command is written, the engine runs a fixed chain of checks. A failing check records an error code. A passing check produces a two-instruction program for the selected halted hart and raises a one-cycle start pulse. The first instruction is a load or store that moves one general-purpose register between the hart and exchange address 0x400. The second is a breakpoint. The engine then stays busy until the hart side reports completion. An exception reported by the hart side is recorded as an error.

The hart side reaches the exchange buffer through its own word port. Fetch tracking on the hart side is done elsewhere.

Top module: `dbg_cmd_engine`

## Requirements
- R1: After reset the error code is 0, busy is 0, all auto-execute bits are 0, `prog_go` is low and every exchange word reads 0.
- R2: A command written while the error code is nonzero is dropped. No program is issued, and the error code and busy flag are unchanged.
- R3: A command written while busy is 1 and the error code is 0 issues nothing and sets the error code to 1 (busy).
- R4: The command type is bits [31:24] of the command word. Any nonzero type sets error code 2 (not supported).
- R5: The register number is bits [15:0] of the command word. Only 0x1000 to 0x101F are accepted, and they select x0 to x31. Any other number sets error code 2.
- R6: If the hart chosen by `hart_sel` does not have its `hart_halted` bit set, error code 4 (halt/resume) is set and no program is issued.
- R7: Size is bits [22:20] of the command word. Code 2 selects 32 bits and code 3 selects 64 bits. Every other code, including 4 (128 bits), sets error code 2.
- R8: An accepted command pulses `prog_go` for exactly one cycle, in the cycle after the write, and sets busy. If the write flag (bit 16) is 1, `prog_insn0` is the load `{12'h400, 5'd0, f3, rd, 7'h03}`. If the write flag is 0, it is the store `{7'h20, rs2, 5'd0, f3, 5'd0, 7'h23}`. In both, f3 is 3'b010 for 32-bit and 3'b011 for 64-bit. `prog_insn1` is the breakpoint 0x00100073.
- R9: A write to the control/status word clears the error code only when the written bits [10:8] are 0. It always loads the auto-execute bits from bits [23:16].
- R10: A `prog_done` pulse clears busy in the next cycle.
- R11: A `prog_exc` pulse sets the error code to 3 only when the error code is 0. Otherwise the error code is kept.
- R12: Bus map:
  - Exchange words 0 to 7 are at addresses 0x00 to 0x07. Word i holds buffer bytes 4i to 4i+3, little-endian.
  - The control/status word is at 0x10. Its fields are count [3:0] (reads 8), error [10:8], busy [12] and auto-execute [23:16].
  - The command word is at 0x11 and reads 0.
  - The hart port reads and writes the same exchange words.
- R13: The checks run in this fixed order: sticky error, busy, type, register range, halted hart, size. The first failing check decides the error code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | ADDR_W | Register bus address |
| bus_wr | input | 1 | Register bus write strobe |
| bus_rd | input | 1 | Register bus read strobe |
| bus_wdata | input | 32 | Register bus write data |
| bus_rdata | output | 32 | Register bus read data (combinational, 0 when not reading) |
| hart_halted | input | NHART | Per-hart halted flags |
| hart_sel | input | SEL_W | Index of the selected hart |
| prog_go | output | 1 | One-cycle start pulse for the issued program |
| prog_insn0 | output | 32 | First program instruction (load or store) |
| prog_insn1 | output | 32 | Second program instruction (breakpoint) |
| prog_done | input | 1 | Hart finished the program |
| prog_exc | input | 1 | Hart took an exception while running the program |
| xb_we | input | 1 | Hart-side exchange word write enable |
| xb_idx | input | IDX_W | Hart-side exchange word index |
| xb_wdata | input | 32 | Hart-side exchange write data |
| xb_rdata | output | 32 | Hart-side exchange read data |

## Verification
The assertions assume the following about the inputs:
- Only one bus write is presented per cycle.
- `prog_done` arrives only while a program is outstanding.
- `prog_exc` is not raised in the same cycle as a command write.

The busy-reject and drop properties also exclude cycles where the hart side reports an exception. The directed stimulus stays within these limits:
- Every bus write is a single-cycle strobe.
- Done and exception pulses are driven only between bus writes, never overlapping them.
- `hart_sel` and `hart_halted` are changed only while no command is being written.

// File: rtl/dce_pkg.sv
// Shared definitions for the debug abstract command engine: error codes,
// bus map, command and status field positions, instruction builders.
package dce_pkg;

    typedef enum logic [2:0] {
        ERR_NONE   = 3'd0,
        ERR_BUSY   = 3'd1,
        ERR_NOTSUP = 3'd2,
        ERR_EXC    = 3'd3,
        ERR_HALT   = 3'd4,
        ERR_OTHER  = 3'd7
    } err_e;

    localparam int ADDR_CS  = 'h10;
    localparam int ADDR_CMD = 'h11;

    localparam logic [15:0] GPR_FIRST = 16'h1000;
    localparam logic [15:0] GPR_LAST  = 16'h101F;
    localparam logic [11:0] XCHG_OFS  = 12'h400;
    localparam logic [31:0] INSN_BRK  = 32'h0010_0073;

    // I-type load into rd from XCHG_OFS(x0)
    function automatic logic [31:0] mk_load(input logic [2:0] f3, input logic [4:0] rd);
        return {XCHG_OFS, 5'd0, f3, rd, 7'b0000011};
    endfunction

    // S-type store of rs2 to XCHG_OFS(x0)
    function automatic logic [31:0] mk_store(input logic [2:0] f3, input logic [4:0] rs2);
        return {XCHG_OFS[11:5], rs2, 5'd0, f3, XCHG_OFS[4:0], 7'b0100011};
    endfunction

endpackage

// File: rtl/dce_xbuf.sv
// Exchange buffer: NWORDS 32-bit words, written from the debug bus or the
// hart port. Assumes at most one write per port per cycle; on a same-word
// collision the bus write wins.
module dce_xbuf #(
    parameter int NWORDS = 8,
    parameter int IDX_W  = $clog2(NWORDS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             bus_we,
    input  logic [IDX_W-1:0] bus_idx,
    input  logic [31:0]      bus_wdata,
    output logic [31:0]      bus_rdata,
    input  logic             hx_we,
    input  logic [IDX_W-1:0] hx_idx,
    input  logic [31:0]      hx_wdata,
    output logic [31:0]      hx_rdata
);
    logic [31:0] words [NWORDS];

    for (genvar i = 0; i < NWORDS; i++) begin : g_word
        // Word i: reset to zero, bus write first, else hart write
        always_ff @(posedge clk) begin
            if (!rst_n)
                words[i] <= '0;
            else if (bus_we && bus_idx == IDX_W'(i))
                words[i] <= bus_wdata;
            else if (hx_we && hx_idx == IDX_W'(i))
                words[i] <= hx_wdata;
        end
    end

    assign bus_rdata = words[bus_idx];
    assign hx_rdata  = words[hx_idx];
endmodule

// File: rtl/dce_check_cmd.sv
// Command checker: applies the ordered checks to a command word and either
// names an error code or yields the first program instruction.
// Purely combinational; assumes err_q/busy_q are the current registered state.
module dce_check_cmd
    import dce_pkg::*;
(
    input  logic [31:0] cmd,
    input  err_e        err_q,
    input  logic        busy_q,
    input  logic        halted_sel,
    output logic        set_err,
    output err_e        err_code,
    output logic        issue,
    output logic [31:0] insn0
);
    logic [7:0]  kind;
    logic [2:0]  size;
    logic        wr_flag;
    logic [15:0] regno;
    logic [2:0]  f3;
    logic        unused_cmd;

    assign kind       = cmd[31:24];
    assign size       = cmd[22:20];
    assign wr_flag    = cmd[16];
    assign regno      = cmd[15:0];
    assign unused_cmd = ^{cmd[23], cmd[19:17]};

    // Ordered check chain: sticky, busy, type, range, halted, size
    always_comb begin
        set_err  = 1'b0;
        err_code = ERR_NONE;
        issue    = 1'b0;
        if (err_q != ERR_NONE) begin
            set_err = 1'b0;
        end else if (busy_q) begin
            set_err = 1'b1; err_code = ERR_BUSY;
        end else if (kind != 8'd0) begin
            set_err = 1'b1; err_code = ERR_NOTSUP;
        end else if (regno < GPR_FIRST || regno > GPR_LAST) begin
            set_err = 1'b1; err_code = ERR_NOTSUP;
        end else if (!halted_sel) begin
            set_err = 1'b1; err_code = ERR_HALT;
        end else if (size != 3'd2 && size != 3'd3) begin
            set_err = 1'b1; err_code = ERR_NOTSUP;
        end else begin
            issue = 1'b1;
        end
    end

    // Width-selected transfer instruction
    always_comb begin
        f3    = {2'b01, size[0]};
        insn0 = wr_flag ? mk_load(f3, regno[4:0]) : mk_store(f3, regno[4:0]);
    end
endmodule

// File: rtl/dce_state.sv
// Engine state: error code, busy, auto-execute bits and the issued program.
// Assumes command and status writes never coincide (single bus address).
module dce_state
    import dce_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs_wr,
    input  logic [2:0]  cs_err_wr,
    input  logic [7:0]  cs_ae_wr,
    input  logic        cmd_wr,
    input  logic        set_err,
    input  err_e        err_code,
    input  logic        issue,
    input  logic [31:0] insn0,
    input  logic        done,
    input  logic        exc,
    output err_e        err_q,
    output logic        busy_q,
    output logic [7:0]  ae_q,
    output logic        go_q,
    output logic [31:0] insn0_q,
    output logic [31:0] insn1_q
);
    // Error code: exception first, then status clear, then command result
    always_ff @(posedge clk) begin
        if (!rst_n)
            err_q <= ERR_NONE;
        else if (exc && err_q == ERR_NONE)
            err_q <= ERR_EXC;
        else if (cs_wr && cs_err_wr == 3'd0)
            err_q <= ERR_NONE;
        else if (cmd_wr && set_err)
            err_q <= err_code;
    end

    // Busy: set on issue, cleared on done
    always_ff @(posedge clk) begin
        if (!rst_n)
            busy_q <= 1'b0;
        else if (cmd_wr && issue)
            busy_q <= 1'b1;
        else if (done)
            busy_q <= 1'b0;
    end

    // Auto-execute bits follow every status write
    always_ff @(posedge clk) begin
        if (!rst_n)
            ae_q <= '0;
        else if (cs_wr)
            ae_q <= cs_ae_wr;
    end

    // Program registers and one-cycle start pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            go_q    <= 1'b0;
            insn0_q <= '0;
            insn1_q <= '0;
        end else begin
            go_q <= cmd_wr && issue;
            if (cmd_wr && issue) begin
                insn0_q <= insn0;
                insn1_q <= INSN_BRK;
            end
        end
    end
endmodule

// File: rtl/dbg_cmd_engine.sv
// Top of the debug abstract command engine: bus decode, read mux, and
// wiring of the checker, state and exchange buffer. Assumes one bus access
// per cycle and combinational read data.
module dbg_cmd_engine
    import dce_pkg::*;
#(
    parameter int ADDR_W = 7,
    parameter int NWORDS = 8,
    parameter int NHART  = 4,
    parameter int IDX_W  = $clog2(NWORDS),
    parameter int SEL_W  = $clog2(NHART)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NHART-1:0]  hart_halted,
    input  logic [SEL_W-1:0]  hart_sel,
    output logic              prog_go,
    output logic [31:0]       prog_insn0,
    output logic [31:0]       prog_insn1,
    input  logic              prog_done,
    input  logic              prog_exc,
    input  logic              xb_we,
    input  logic [IDX_W-1:0]  xb_idx,
    input  logic [31:0]       xb_wdata,
    output logic [31:0]       xb_rdata
);
    localparam logic [3:0] COUNT = 4'(NWORDS);

    logic        is_data, cs_wr, cmd_wr, data_wr;
    logic        set_err, issue, busy_q;
    err_e        err_code, err_q;
    logic [31:0] insn0, data_rd, cs_word;
    logic [7:0]  ae_q;
    logic [31:0] rd_mux;
    logic        unused_wdata;

    assign is_data      = bus_addr < ADDR_W'(NWORDS);
    assign data_wr      = bus_wr && is_data;
    assign cs_wr        = bus_wr && bus_addr == ADDR_W'(ADDR_CS);
    assign cmd_wr       = bus_wr && bus_addr == ADDR_W'(ADDR_CMD);
    assign unused_wdata = ^{bus_wdata[31:24], bus_wdata[15:11]};

    dce_check_cmd u_check (
        .cmd        (bus_wdata),
        .err_q      (err_q),
        .busy_q     (busy_q),
        .halted_sel (hart_halted[hart_sel]),
        .set_err    (set_err),
        .err_code   (err_code),
        .issue      (issue),
        .insn0      (insn0)
    );

    dce_state u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_wr     (cs_wr),
        .cs_err_wr (bus_wdata[10:8]),
        .cs_ae_wr  (bus_wdata[23:16]),
        .cmd_wr    (cmd_wr),
        .set_err   (set_err),
        .err_code  (err_code),
        .issue     (issue),
        .insn0     (insn0),
        .done      (prog_done),
        .exc       (prog_exc),
        .err_q     (err_q),
        .busy_q    (busy_q),
        .ae_q      (ae_q),
        .go_q      (prog_go),
        .insn0_q   (prog_insn0),
        .insn1_q   (prog_insn1)
    );

    dce_xbuf #(.NWORDS(NWORDS), .IDX_W(IDX_W)) u_xbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (data_wr),
        .bus_idx   (bus_addr[IDX_W-1:0]),
        .bus_wdata (bus_wdata),
        .bus_rdata (data_rd),
        .hx_we     (xb_we),
        .hx_idx    (xb_idx),
        .hx_wdata  (xb_wdata),
        .hx_rdata  (xb_rdata)
    );

    assign cs_word = {8'd0, ae_q, 3'd0, busy_q, 1'b0, err_q, 4'd0, COUNT};

    // Read mux: data words, status word; command and holes read 0
    always_comb begin
        rd_mux = '0;
        if (is_data)
            rd_mux = data_rd;
        else if (bus_addr == ADDR_W'(ADDR_CS))
            rd_mux = cs_word;
        bus_rdata = bus_rd ? rd_mux : 32'd0;
    end
endmodule

// File: rtl/dce_checker.sv
// Temporal checks for dbg_cmd_engine, bound to every instance.
// Assumes exceptions do not coincide with command writes.
module dce_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cmd_wr,
    input logic [2:0] err,
    input logic       busy,
    input logic       go,
    input logic       halted_sel,
    input logic       done,
    input logic       exc
);
    a_r2_drop_when_err: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && err != 3'd0 && !exc |=> $stable(err) && !go);

    a_r3_busy_reject: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_wr && err == 3'd0 && busy && !exc |=> err == 3'd1 && !go);

    a_r6_go_needs_halt: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> $past(halted_sel));

    a_r8_go_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> busy);

    a_r8_go_single: assert property (@(posedge clk) disable iff (!rst_n)
        go |=> !go);

    a_r10_done_clears: assert property (@(posedge clk) disable iff (!rst_n)
        done && !cmd_wr |=> !busy);

    a_r11_exc_records: assert property (@(posedge clk) disable iff (!rst_n)
        exc && err == 3'd0 |=> err == 3'd3);
endmodule

bind dbg_cmd_engine dce_checker u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (cmd_wr),
    .err        (err_q),
    .busy       (busy_q),
    .go         (prog_go),
    .halted_sel (hart_halted[hart_sel]),
    .done       (prog_done),
    .exc        (prog_exc)
);

// File: tb/sim_dbg_cmd_engine.sv
// Directed bench for dbg_cmd_engine: one task per scenario.
module sim_dbg_cmd_engine;
    logic        clk = 0;
    logic        rst_n = 0;
    logic [6:0]  bus_addr = 0;
    logic        bus_wr = 0, bus_rd = 0;
    logic [31:0] bus_wdata = 0;
    logic [31:0] bus_rdata;
    logic [3:0]  hart_halted = 0;
    logic [1:0]  hart_sel = 0;
    logic        prog_go;
    logic [31:0] prog_insn0, prog_insn1;
    logic        prog_done = 0, prog_exc = 0;
    logic        xb_we = 0;
    logic [2:0]  xb_idx = 0;
    logic [31:0] xb_wdata = 0;
    logic [31:0] xb_rdata;

    int checks = 0;
    int errors = 0;

    localparam logic [6:0] A_CS = 7'h10, A_CMD = 7'h11;

    always #2 clk = ~clk;

    dbg_cmd_engine u0 (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] mk_cmd(logic [7:0] ty, logic [2:0] sz, logic wr, logic [15:0] rn);
        return {ty, 1'b0, sz, 3'b000, wr, rn};
    endfunction

    function automatic logic [31:0] exp_cs(logic [7:0] ae, logic busy, logic [2:0] err);
        return {8'd0, ae, 3'd0, busy, 1'b0, err, 4'd0, 4'd8};
    endfunction

    function automatic logic [31:0] exp_insn(logic wr, logic wide, logic [4:0] r);
        logic [2:0] f3 = wide ? 3'b011 : 3'b010;
        if (wr) return {12'h400, 5'd0, f3, r, 7'h03};
        return {7'h20, r, 5'd0, f3, 5'd0, 7'h23};
    endfunction

    task automatic bus_write(logic [6:0] a, logic [31:0] d);
        @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1;
        @(negedge clk); bus_wr = 0;
    endtask

    task automatic bus_read(logic [6:0] a, output logic [31:0] d);
        bus_addr = a; bus_rd = 1; #1; d = bus_rdata; bus_rd = 0;
    endtask

    task automatic pulse_done();
        @(negedge clk); prog_done = 1; @(negedge clk); prog_done = 0;
    endtask

    task automatic pulse_exc();
        @(negedge clk); prog_exc = 1; @(negedge clk); prog_exc = 0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        bus_read(A_CS, d);   check("R1 status", d, exp_cs(0, 0, 0));
        check("R1 go", {31'd0, prog_go}, 0);
        bus_read(7'h03, d);  check("R1 data", d, 0);
        bus_read(A_CMD, d);  check("R12 cmd reads 0", d, 0);
    endtask

    task automatic t_data();
        logic [31:0] d;
        for (int i = 0; i < 8; i++) bus_write(7'(i), 32'hA000_0000 + i * 32'h0101);
        for (int i = 0; i < 8; i++) begin
            bus_read(7'(i), d); check("R12 data rw", d, 32'hA000_0000 + i * 32'h0101);
        end
        xb_idx = 2; #1; check("R12 hart read", xb_rdata, 32'hA000_0202);
        @(negedge clk); xb_we = 1; xb_idx = 5; xb_wdata = 32'h1234_5678;
        @(negedge clk); xb_we = 0;
        bus_read(7'h05, d); check("R12 hart write", d, 32'h1234_5678);
    endtask

    task automatic t_issue(logic wr, logic wide, logic [4:0] r);
        logic [31:0] d;
        hart_halted = 4'b0010; hart_sel = 1;
        bus_write(A_CMD, mk_cmd(0, wide ? 3'd3 : 3'd2, wr, 16'h1000 + 16'(r)));
        check("R8 go pulse", {31'd0, prog_go}, 1);
        check("R8 insn0", prog_insn0, exp_insn(wr, wide, r));
        check("R8 insn1", prog_insn1, 32'h0010_0073);
        bus_read(A_CS, d); check("R8 busy set", d, exp_cs(0, 1, 0));
        @(negedge clk); check("R8 go one cycle", {31'd0, prog_go}, 0);
        pulse_done();
        bus_read(A_CS, d); check("R10 done clears busy", d, exp_cs(0, 0, 0));
    endtask

    task automatic t_err(string req, logic [31:0] cmd, logic [2:0] code);
        logic [31:0] d;
        bus_write(A_CMD, cmd);
        check({req, " no go"}, {31'd0, prog_go}, 0);
        bus_read(A_CS, d); check(req, d, exp_cs(0, 0, code));
        bus_write(A_CS, 0);
    endtask

    task automatic t_busy_and_cs();
        logic [31:0] d;
        hart_halted = 4'b0001; hart_sel = 0;
        bus_write(A_CMD, mk_cmd(0, 2, 1, 16'h1003));
        bus_write(A_CMD, mk_cmd(0, 2, 1, 16'h1003));
        check("R3 no go", {31'd0, prog_go}, 0);
        bus_read(A_CS, d); check("R3 busy code", d, exp_cs(0, 1, 1));
        bus_write(A_CS, {8'd0, 8'hA5, 5'd0, 3'd1, 8'd0});
        bus_read(A_CS, d); check("R9 nonzero keeps err", d, exp_cs(8'hA5, 1, 1));
        bus_write(A_CMD, mk_cmd(0, 2, 1, 16'h1003));
        check("R2 dropped no go", {31'd0, prog_go}, 0);
        bus_read(A_CS, d); check("R2 state kept", d, exp_cs(8'hA5, 1, 1));
        bus_write(A_CS, {8'd0, 8'h3C, 16'd0});
        bus_read(A_CS, d); check("R9 zero clears", d, exp_cs(8'h3C, 1, 0));
        bus_write(A_CMD, mk_cmd(8'h02, 2, 1, 16'h1003));
        bus_read(A_CS, d); check("R13 busy before type", d, exp_cs(8'h3C, 1, 1));
        bus_write(A_CS, 0);
        pulse_done();
        bus_write(A_CS, {5'd0, 3'd2, 8'd0});
        bus_read(A_CS, d); check("R9 ae cleared err kept", d, exp_cs(0, 0, 0));
    endtask

    task automatic t_exc();
        logic [31:0] d;
        hart_halted = 4'b1000; hart_sel = 3;
        bus_write(A_CMD, mk_cmd(0, 3, 0, 16'h1010));
        pulse_exc();
        bus_read(A_CS, d); check("R11 exc sets 3", d, exp_cs(0, 1, 3));
        pulse_done();
        bus_write(A_CS, 0);
        bus_write(A_CMD, mk_cmd(1, 2, 0, 16'h1000));
        pulse_exc();
        bus_read(A_CS, d); check("R11 exc keeps 2", d, exp_cs(0, 0, 2));
        bus_write(A_CS, 0);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        t_reset();
        t_data();
        t_issue(1, 0, 5'd5);
        t_issue(0, 1, 5'd31);
        t_issue(1, 1, 5'd0);
        t_busy_and_cs();
        hart_halted = 4'b0001; hart_sel = 0;
        t_err("R4 type", mk_cmd(8'h01, 2, 1, 16'h1001), 3'd2);
        t_err("R5 below range", mk_cmd(0, 2, 1, 16'h0FFF), 3'd2);
        t_err("R5 above range", mk_cmd(0, 2, 1, 16'h1020), 3'd2);
        t_err("R7 size 128", mk_cmd(0, 4, 1, 16'h1001), 3'd2);
        t_err("R7 size 16", mk_cmd(0, 1, 0, 16'h1001), 3'd2);
        hart_sel = 2;
        t_err("R6 not halted", mk_cmd(0, 2, 1, 16'h1001), 3'd4);
        t_err("R13 halt before size", mk_cmd(0, 4, 1, 16'h1001), 3'd4);
        t_err("R13 range before halt", mk_cmd(0, 2, 1, 16'h2000), 3'd2);
        t_exc();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule